// File: doc/BRIEF.md
# Integer Square Root Unit

A register-mapped unit that returns the floor of the square root of an unsigned operand. Software fills two 32-bit halves of a 64-bit parameter register and then writes a control register, whose bit 0 chooses between the low half only or the whole 64-bit value. The unit then runs a digit-by-digit recurrence that settles one result bit per clock. The answer appears in a 32-bit result register, and a busy flag in the control register reports when the answer is ready.

A narrow (32-bit) root needs 16 clocks and a wide (64-bit) root needs 32. Any write to the parameter halves or to the control register abandons the current run and starts over from the new contents. The unit does not check whether software polls busy before it reads the result.

Top module: `isqrt_unit`

## Requirements
- R1: After reset, the parameter reads 0, the control register reads 0 (busy clear, narrow width) and the result reads 0.
- R2: When control bit 0 is 0, only bits 31:0 of the parameter feed the root, and the upper half has no effect on the result.
- R3: When control bit 0 is 1, all 64 parameter bits feed the root.
- R4: The result r satisfies r*r <= operand < (r+1)*(r+1), so r is the floor of the square root.
- R5: Control bit 15 (busy) reads 1 from the clock after a write to address 0, 1 or 2. It clears on the edge that loads the result, which is 16 clocks after the write in narrow mode and 32 clocks after it in wide mode. The result register changes only on that edge.
- R6: A write to address 0, 1 or 2 while busy is set abandons the run and restarts it from the updated registers, with the full latency counted from that write.
- R7: An operand of zero gives 0. An all-ones 64-bit operand in wide mode gives 0xFFFFFFFF.
- R8: The register map is: address 0 for parameter bits 31:0, address 1 for bits 63:32, address 2 for control (bit 0 width, bit 15 busy, read-only), and address 3 for the result (read-only). A write to address 3 changes nothing and does not set busy. Parameter halves and the width bit read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | DW | Register read data, combinational from rd_addr |

## Verification
The hardest situation to reach from the ports is a restart in mid-run, because the remainder and the partial root are invisible and a stale run can look correct. The bench first starts a wide root of an all-ones operand. A few clocks later it switches the width to narrow. It then checks both the narrow answer and the exact 16-clock latency measured from the second write. The bench also drives operands with junk in the upper half in narrow mode, and operands that sit one below and exactly on a perfect square near 2^64.

// File: rtl/isqrt_unit.sv
module isqrt_unit #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int PW       = 2 * DW;
  localparam int CW       = $clog2(DW);
  localparam int BUSY_BIT = 15;
  localparam logic [CW-1:0] WIDE_START   = CW'(DW - 1);
  localparam logic [CW-1:0] NARROW_START = CW'(DW / 2 - 1);

  logic [PW-1:0] param_q, param_nx;
  logic          wide_q, wide_nx;
  logic          busy_q;
  logic [PW-1:0] rem_q, acc_q;
  logic [CW-1:0] step_q;
  logic [DW-1:0] result_q;

  logic          load;
  logic [PW-1:0] operand, bit_v, trial, acc_nx;
  logic          take;

  assign load = wr_en && (wr_addr != 2'd3);

  always_comb begin
    param_nx = param_q;
    wide_nx  = wide_q;
    if (wr_en && wr_addr == 2'd0) param_nx[DW-1:0]  = wr_data;
    if (wr_en && wr_addr == 2'd1) param_nx[PW-1:DW] = wr_data;
    if (wr_en && wr_addr == 2'd2) wide_nx           = wr_data[0];
  end

  assign operand = wide_nx ? param_nx : {{DW{1'b0}}, param_nx[DW-1:0]};
  assign bit_v   = {{(PW-1){1'b0}}, 1'b1} << {step_q, 1'b0};
  assign trial   = acc_q + bit_v;
  assign take    = rem_q >= trial;
  assign acc_nx  = take ? ((acc_q >> 1) + bit_v) : (acc_q >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      param_q  <= '0;
      wide_q   <= 1'b0;
      busy_q   <= 1'b0;
      rem_q    <= '0;
      acc_q    <= '0;
      step_q   <= '0;
      result_q <= '0;
    end else if (load) begin
      param_q <= param_nx;
      wide_q  <= wide_nx;
      busy_q  <= 1'b1;
      rem_q   <= operand;
      acc_q   <= '0;
      step_q  <= wide_nx ? WIDE_START : NARROW_START;
    end else if (busy_q) begin
      acc_q <= acc_nx;
      if (take) rem_q <= rem_q - trial;
      if (step_q == '0) begin
        busy_q   <= 1'b0;
        result_q <= acc_nx[DW-1:0];
      end else begin
        step_q <= step_q - 1'b1;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      2'd0: rd_data = param_q[DW-1:0];
      2'd1: rd_data = param_q[PW-1:DW];
      2'd2: begin
        rd_data[0]        = wide_q;
        rd_data[BUSY_BIT] = busy_q;
      end
      default: rd_data = result_q;
    endcase
  end
endmodule

// File: rtl/isqrt_unit_chk.sv
module isqrt_unit_chk #(
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [1:0]      wr_addr,
  input logic            busy,
  input logic            wide,
  input logic [2*DW-1:0] param,
  input logic [DW-1:0]   result
);
  localparam int PW = 2 * DW;
  logic [PW-1:0]   opnd;
  logic [PW+1:0]   sq_lo, sq_hi;

  assign opnd  = wide ? param : {{DW{1'b0}}, param[DW-1:0]};
  assign sq_lo = (PW+2)'(result) * (PW+2)'(result);
  assign sq_hi = ((PW+2)'(result) + 1'b1) * ((PW+2)'(result) + 1'b1);

  a_r5_busy_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != 2'd3) |=> busy);

  a_r5_result_only_at_finish: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(result));

  a_r8_result_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd3 && !busy) |=> !busy);

  a_r4_floor_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> sq_lo <= (PW+2)'(opnd));

  a_r4_floor_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> sq_hi > (PW+2)'(opnd));

  a_r2_narrow_range: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !wide) |-> result[DW-1:DW/2] == '0);
endmodule

bind isqrt_unit isqrt_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .busy(busy_q), .wide(wide_q), .param(param_q), .result(result_q)
);

// File: tb/isqrt_unit_bench.sv
module isqrt_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  int checks = 0;
  int fails = 0;

  isqrt_unit u_isqrt_unit (.*);

  always #5 clk = ~clk;

  localparam int NV = 16;
  localparam logic [96:0] VEC [NV] = '{
    {1'b1, 64'd0, 32'd0},
    {1'b1, 64'd1, 32'd1},
    {1'b1, 64'd2, 32'd1},
    {1'b1, 64'd3, 32'd1},
    {1'b1, 64'd4, 32'd2},
    {1'b1, 64'd15, 32'd3},
    {1'b1, 64'd16, 32'd4},
    {1'b1, 64'd1000000, 32'd1000},
    {1'b1, 64'h4000000000000000, 32'h80000000},
    {1'b1, 64'hFFFFFFFE00000001, 32'hFFFFFFFF},
    {1'b1, 64'hFFFFFFFE00000000, 32'hFFFFFFFE},
    {1'b1, 64'hFFFFFFFFFFFFFFFF, 32'hFFFFFFFF},
    {1'b0, 64'd99, 32'd9},
    {1'b0, 64'hFFFFFFFF00000010, 32'd4},
    {1'b0, 64'h12345678FFFFFFFF, 32'h0000FFFF},
    {1'b0, 64'hABCDEF0000000000, 32'd0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_done(output int cyc);
    logic [31:0] c;
    cyc = 0;
    rd(2'd2, c);
    while (c[15] && cyc < 100) begin
      @(negedge clk);
      cyc++;
      rd(2'd2, c);
    end
  endtask

  task automatic run(input logic w, input logic [63:0] p, output logic [31:0] r, output int cyc);
    wr(2'd0, p[31:0]);
    wr(2'd1, p[63:32]);
    wr(2'd2, {31'd0, w});
    wait_done(cyc);
    rd(2'd3, r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] r, c;
    int cyc;
    repeat (3) @(negedge clk);
    rd(2'd0, r); check("R1 param lo", r, 0);
    rd(2'd2, r); check("R1 control", r, 0);
    rd(2'd3, r); check("R1 result", r, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run(VEC[i][96], VEC[i][95:32], r, cyc);
      check(VEC[i][96] ? "R3 R4 R7 wide vector" : "R2 R4 narrow vector", r, VEC[i][31:0]);
      check("R5 latency", cyc, VEC[i][96] ? 32 : 16);
    end

    for (int i = 0; i < 40; i++) begin
      logic [63:0] p, op;
      logic [65:0] lo, hi;
      logic w;
      p = {$urandom, $urandom};
      if (i % 4 == 0) p = p >> (i % 60);
      w = i[0];
      run(w, p, r, cyc);
      op = w ? p : {32'd0, p[31:0]};
      lo = 66'(r) * 66'(r);
      hi = (66'(r) + 1) * (66'(r) + 1);
      check("R4 floor bound", {63'd0, (lo <= 66'(op)) && (hi > 66'(op))}, 1);
    end

    run(1'b1, 64'hFFFFFFFFFFFFFFFF, r, cyc);
    wr(2'd2, 32'd1);
    repeat (5) @(negedge clk);
    wr(2'd2, 32'd0);
    wait_done(cyc);
    rd(2'd3, r);
    check("R6 restart result", r, 32'h0000FFFF);
    check("R6 restart latency", cyc, 16);

    rd(2'd3, c);
    wr(2'd3, 32'h12345678);
    rd(2'd3, r); check("R8 result write ignored", r, c);
    rd(2'd2, r); check("R8 no busy on result write", r, 0);
    rd(2'd0, r); check("R8 param lo readback", r, 32'hFFFFFFFF);
    rd(2'd1, r); check("R8 param hi readback", r, 32'hFFFFFFFF);

    wr(2'd2, 32'd1);
    rd(2'd2, r); check("R5 busy set", r, 32'h8001);
    wait_done(cyc);
    rd(2'd3, r); check("R7 all ones wide", r, 32'hFFFFFFFF);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule